// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between an out-of-order execution core and the architectural register file. It accepts groups of up to two decoded instructions per cycle and places them, in program order, into a six-entry circular buffer. Execution units finish in any order. Each one reports its result, together with an exception flag, against the entry index that was handed out at dispatch. That index serves as the instruction's tag.

Retirement takes only the oldest entry, one per cycle. A clean result is written into the internal register file. A result carrying an exception empties the whole buffer and raises a one-cycle flush with the faulting instruction address, so the architectural state is exactly that of the instructions older than the fault.

Operand lookup ports let the dispatch stage resolve sources. A source first checks the older instructions of the same dispatch group, then the youngest buffer entry writing that register, and finally the register file.

A two-state controller governs the block:
- `ST_RUN` is normal operation: dispatch, writeback and retirement.
- `ST_RECOVER` is the single flush cycle.
- The transition `ST_RUN -> ST_RECOVER` is taken when the oldest entry is complete and marked excepting.
- The transition `ST_RECOVER -> ST_RUN` always follows after one cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. `disp_ready` is 1, `cm_valid` and `flush` are 0, and every register reads as value 0 through the lookup ports.
- R2: Accepted instructions take consecutive tags in program order. Slot 0 is older than slot 1. Slot 1 takes the next index after slot 0 when slot 0 is valid. Tags run 0 to 5 and wrap from 5 to 0.
- R3: A dispatch group is accepted only when the number of free entries is at least the number of valid slots. `disp_ready` reports acceptance in the same cycle, and a refused group allocates nothing.
- R4: A writeback (`wb_valid`, `wb_tag`, `wb_value`, `wb_exc`) marks the tagged entry complete and stores its result and exception flag. The entry is visible from the next cycle.
- R5: Only the oldest entry retires, at most one per cycle. When it is complete without an exception, `cm_valid` is 1 with its destination register and value, and the register file is updated at that clock edge. If the oldest entry is incomplete, nothing retires, even if younger entries are complete.
- R6: When the oldest entry is complete with its exception flag set, the following happens. The buffer is emptied and nothing of it retires. In the next cycle `flush` is 1 for exactly one cycle, and `exc_pc` holds that entry's address. `disp_ready` is 0 in that cycle. The first dispatch after the flush receives tag 0.
- R7: A source register with no match in the same group is looked up in the buffer, and the youngest occupied entry with that destination is used. If that entry is complete, `lk_rdy`=1 and `lk_val` is its result. Otherwise `lk_rdy`=0 and `lk_tag` is its index.
- R8: A source with no match in the group or the buffer returns `lk_rdy`=1 with the register file value.
- R9: Lookup ports 2 and 3 belong to slot 1. A source there that equals the destination of a valid slot 0 returns `lk_rdy`=0 with slot 0's tag, ahead of any buffer or register file match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | NDISP | Valid bit per dispatch slot, slot 0 oldest |
| disp_pc | input | NDISP x PC_W | Instruction address per slot |
| disp_dreg | input | NDISP x RW | Destination register per slot |
| disp_ready | output | 1 | Group accepted this cycle |
| disp_tag | output | NDISP x TW | Tag assigned to each slot |
| lk_reg | input | NLK x RW | Source register per lookup port (port = slot*NSRC + source) |
| lk_rdy | output | NLK | Lookup value available |
| lk_val | output | NLK x XLEN | Lookup value |
| lk_tag | output | NLK x TW | Producer tag when not available |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TW | Entry being completed |
| wb_value | input | XLEN | Result |
| wb_exc | input | 1 | Result raised an exception |
| cm_valid | output | 1 | Oldest entry retires this cycle |
| cm_reg | output | RW | Retiring destination register |
| cm_value | output | XLEN | Retiring value |
| flush | output | 1 | One-cycle pipeline flush |
| exc_pc | output | PC_W | Address of the faulting instruction |

## Verification
The bench completes entries out of order, with a younger entry finished while the oldest is still waiting. A design that retired by completion would commit a wrong register value out of turn.

It fills the buffer across the wrap point and offers groups larger than the free space, once with one entry free and once with none. A wrong free-count comparison would then overwrite live entries or duplicate tags.

An exception is placed in the middle of a run whose younger entries are already complete. A missing flush, or a leak of a younger result, shows up in the register file and in the tag handed out after the flush.

Lookups target registers with two pending writers and registers written by the same dispatch group. A design that returned the oldest match, or that ignored the group, would hand out stale tags.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rob_state_e;

    // fold a ring position that may exceed the ring once
    function automatic int ring_fold(input int pos, input int depth);
        return (pos >= depth) ? pos - depth : pos;
    endfunction

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NDISP = 2,
    parameter int PC_W  = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NDISP-1:0]           disp_valid,
    input  logic                       head_rdy,
    input  logic                       head_exc,
    input  logic [PC_W-1:0]            head_pc,
    output logic                       disp_ready,
    output logic                       alloc_fire,
    output logic                       commit_fire,
    output logic                       run,
    output logic                       flush,
    output logic [TW-1:0]              head_ptr,
    output logic [CW-1:0]              count,
    output logic [NDISP-1:0][TW-1:0]   slot_tag,
    output logic [PC_W-1:0]            exc_pc
);

    rob_state_e state, state_nx;
    logic [TW-1:0] tail_ptr;
    logic [CW-1:0] nreq, nadd, free_n;
    logic          exc_take;

    always_comb begin
        nreq = '0;
        for (int s = 0; s < NDISP; s++) begin
            nreq = nreq + CW'(disp_valid[s]);
        end
    end

    always_comb begin
        int off;
        off = 0;
        for (int s = 0; s < NDISP; s++) begin
            slot_tag[s] = TW'(ring_fold(int'(tail_ptr) + off, DEPTH));
            off = off + int'(disp_valid[s]);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (exc_take) state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_RUN;
            default:    state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // outputs decoded from state and buffer occupancy
    always_comb begin
        run         = (state == ST_RUN);
        flush       = (state == ST_RECOVER);
        free_n      = CW'(DEPTH) - count;
        exc_take    = run && (count != '0) && head_rdy && head_exc;
        commit_fire = run && (count != '0) && head_rdy && !head_exc;
        disp_ready  = run && !exc_take && (free_n >= nreq);
        alloc_fire  = disp_ready && (|disp_valid);
        nadd        = alloc_fire ? nreq : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
            exc_pc   <= '0;
        end else if (exc_take) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
            exc_pc   <= head_pc;
        end else begin
            if (commit_fire) head_ptr <= TW'(ring_fold(int'(head_ptr) + 1, DEPTH));
            tail_ptr <= TW'(ring_fold(int'(tail_ptr) + int'(nadd), DEPTH));
            count    <= count + nadd - CW'(commit_fire);
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_stall_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready) |=> (count <= $past(count)));

    assert_flush_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (count == '0 && head_ptr == '0));

endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
    parameter int DEPTH = 6,
    parameter int NDISP = 2,
    parameter int PC_W  = 16,
    parameter int XLEN  = 16,
    parameter int RW    = 3,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_fire,
    input  logic [NDISP-1:0]              disp_valid,
    input  logic [NDISP-1:0][TW-1:0]      slot_tag,
    input  logic [NDISP-1:0][PC_W-1:0]    disp_pc,
    input  logic [NDISP-1:0][RW-1:0]      disp_dreg,
    input  logic                          wb_en,
    input  logic [TW-1:0]                 wb_tag,
    input  logic [XLEN-1:0]               wb_value,
    input  logic                          wb_exc,
    input  logic [TW-1:0]                 head_ptr,
    output logic [DEPTH-1:0]              e_rdy,
    output logic [DEPTH-1:0][RW-1:0]      e_dreg,
    output logic [DEPTH-1:0][XLEN-1:0]    e_res,
    output logic                          head_rdy,
    output logic                          head_exc,
    output logic [PC_W-1:0]               head_pc,
    output logic [RW-1:0]                 head_dreg,
    output logic [XLEN-1:0]               head_res
);

    logic [DEPTH-1:0]           e_exc;
    logic [DEPTH-1:0][PC_W-1:0] e_pc;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic            hit;
        logic            rdy_q, exc_q;
        logic [PC_W-1:0] pc_q;
        logic [RW-1:0]   dreg_q;
        logic [XLEN-1:0] res_q;

        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NDISP; s++) begin
                if (alloc_fire && disp_valid[s] && slot_tag[s] == TW'(e)) hit = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q  <= 1'b0;
                exc_q  <= 1'b0;
                pc_q   <= '0;
                dreg_q <= '0;
                res_q  <= '0;
            end else if (hit) begin
                for (int s = 0; s < NDISP; s++) begin
                    if (disp_valid[s] && slot_tag[s] == TW'(e)) begin
                        pc_q   <= disp_pc[s];
                        dreg_q <= disp_dreg[s];
                    end
                end
                rdy_q <= 1'b0;
                exc_q <= 1'b0;
                res_q <= '0;
            end else if (wb_en && wb_tag == TW'(e)) begin
                rdy_q <= 1'b1;
                exc_q <= wb_exc;
                res_q <= wb_value;
            end
        end

        assign e_rdy[e]  = rdy_q;
        assign e_exc[e]  = exc_q;
        assign e_pc[e]   = pc_q;
        assign e_dreg[e] = dreg_q;
        assign e_res[e]  = res_q;
    end

    assign head_rdy  = e_rdy[head_ptr];
    assign head_exc  = e_exc[head_ptr];
    assign head_pc   = e_pc[head_ptr];
    assign head_dreg = e_dreg[head_ptr];
    assign head_res  = e_res[head_ptr];

    assert_wb_marks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (e_rdy[$past(wb_tag)] || $past(alloc_fire)));

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NDISP = 2,
    parameter int NSRC  = 2,
    parameter int XLEN  = 16,
    parameter int RW    = 3,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NLK  = NDISP * NSRC
) (
    input  logic [DEPTH-1:0]              e_rdy,
    input  logic [DEPTH-1:0][RW-1:0]      e_dreg,
    input  logic [DEPTH-1:0][XLEN-1:0]    e_res,
    input  logic [TW-1:0]                 head_ptr,
    input  logic [CW-1:0]                 count,
    input  logic [NDISP-1:0]              disp_valid,
    input  logic [NDISP-1:0][RW-1:0]      disp_dreg,
    input  logic [NDISP-1:0][TW-1:0]      slot_tag,
    input  logic [NLK-1:0][RW-1:0]        lk_reg,
    input  logic [NLK-1:0][XLEN-1:0]      rf_data,
    output logic [NLK-1:0]                lk_rdy,
    output logic [NLK-1:0][XLEN-1:0]      lk_val,
    output logic [NLK-1:0][TW-1:0]        lk_tag
);

    for (genvar q = 0; q < NLK; q++) begin : g_port
        localparam int SLOT = q / NSRC;
        logic          hit, grp;
        logic [TW-1:0] hidx, gtag;

        // youngest occupied entry writing this register
        always_comb begin
            int idx;
            hit  = 1'b0;
            hidx = '0;
            for (int k = 0; k < DEPTH; k++) begin
                idx = ring_fold(int'(head_ptr) + k, DEPTH);
                if (k < int'(count) && e_dreg[TW'(idx)] == lk_reg[q]) begin
                    hit  = 1'b1;
                    hidx = TW'(idx);
                end
            end
        end

        // youngest older slot of the same group writing this register
        always_comb begin
            grp  = 1'b0;
            gtag = '0;
            for (int s = 0; s < SLOT; s++) begin
                if (disp_valid[s] && disp_dreg[s] == lk_reg[q]) begin
                    grp  = 1'b1;
                    gtag = slot_tag[s];
                end
            end
        end

        always_comb begin
            if (grp) begin
                lk_rdy[q] = 1'b0;
                lk_val[q] = '0;
                lk_tag[q] = gtag;
            end else if (hit) begin
                lk_rdy[q] = e_rdy[hidx];
                lk_val[q] = e_rdy[hidx] ? e_res[hidx] : '0;
                lk_tag[q] = hidx;
            end else begin
                lk_rdy[q] = 1'b1;
                lk_val[q] = rf_data[q];
                lk_tag[q] = '0;
            end
        end
    end

endmodule

// File: rtl/rob_regfile.sv
module rob_regfile #(
    parameter int NREG = 8,
    parameter int XLEN = 16,
    parameter int NRD  = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [RW-1:0]            waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [NRD-1:0][RW-1:0]   raddr,
    output logic [NRD-1:0][XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) mem[r] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NREG  = 8,
    parameter int XLEN  = 16,
    parameter int PC_W  = 16,
    parameter int NDISP = 2,
    parameter int NSRC  = 2,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NLK  = NDISP * NSRC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NDISP-1:0]           disp_valid,
    input  logic [NDISP-1:0][PC_W-1:0] disp_pc,
    input  logic [NDISP-1:0][RW-1:0]   disp_dreg,
    output logic                       disp_ready,
    output logic [NDISP-1:0][TW-1:0]   disp_tag,
    input  logic [NLK-1:0][RW-1:0]     lk_reg,
    output logic [NLK-1:0]             lk_rdy,
    output logic [NLK-1:0][XLEN-1:0]   lk_val,
    output logic [NLK-1:0][TW-1:0]     lk_tag,
    input  logic                       wb_valid,
    input  logic [TW-1:0]              wb_tag,
    input  logic [XLEN-1:0]            wb_value,
    input  logic                       wb_exc,
    output logic                       cm_valid,
    output logic [RW-1:0]              cm_reg,
    output logic [XLEN-1:0]            cm_value,
    output logic                       flush,
    output logic [PC_W-1:0]            exc_pc
);

    logic                     alloc_fire, commit_fire, run;
    logic [TW-1:0]            head_ptr;
    logic [CW-1:0]            count;
    logic                     head_rdy, head_exc;
    logic [PC_W-1:0]          head_pc;
    logic [DEPTH-1:0]         e_rdy;
    logic [DEPTH-1:0][RW-1:0] e_dreg;
    logic [DEPTH-1:0][XLEN-1:0] e_res;
    logic [NLK-1:0][XLEN-1:0] rf_data;

    rob_ctrl #(.DEPTH(DEPTH), .NDISP(NDISP), .PC_W(PC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
        .head_rdy(head_rdy), .head_exc(head_exc), .head_pc(head_pc),
        .disp_ready(disp_ready), .alloc_fire(alloc_fire), .commit_fire(commit_fire),
        .run(run), .flush(flush), .head_ptr(head_ptr), .count(count),
        .slot_tag(disp_tag), .exc_pc(exc_pc)
    );

    rob_entries #(.DEPTH(DEPTH), .NDISP(NDISP), .PC_W(PC_W), .XLEN(XLEN), .RW(RW)) u_entries (
        .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .disp_valid(disp_valid),
        .slot_tag(disp_tag), .disp_pc(disp_pc), .disp_dreg(disp_dreg),
        .wb_en(wb_valid && run), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
        .head_ptr(head_ptr), .e_rdy(e_rdy), .e_dreg(e_dreg), .e_res(e_res),
        .head_rdy(head_rdy), .head_exc(head_exc), .head_pc(head_pc),
        .head_dreg(cm_reg), .head_res(cm_value)
    );

    rob_lookup #(.DEPTH(DEPTH), .NDISP(NDISP), .NSRC(NSRC), .XLEN(XLEN), .RW(RW)) u_lookup (
        .e_rdy(e_rdy), .e_dreg(e_dreg), .e_res(e_res), .head_ptr(head_ptr), .count(count),
        .disp_valid(disp_valid), .disp_dreg(disp_dreg), .slot_tag(disp_tag),
        .lk_reg(lk_reg), .rf_data(rf_data),
        .lk_rdy(lk_rdy), .lk_val(lk_val), .lk_tag(lk_tag)
    );

    rob_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NLK)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(commit_fire), .waddr(cm_reg), .wdata(cm_value),
        .raddr(lk_reg), .rdata(rf_data)
    );

    assign cm_valid = commit_fire;

    assert_retire_excludes_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cm_valid && flush));

    assert_retire_only_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> !flush);

    if (NDISP > 1) begin : g_tagchk
        assert_slot_tags_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid[0] && disp_valid[1] && disp_ready) |-> (disp_tag[0] != disp_tag[1]));
    end

endmodule

// File: tb/tb_rob_top.sv
module tb_rob_top;

    localparam int DEPTH = 6, NREG = 8, XLEN = 16, PC_W = 16, NDISP = 2, NSRC = 2;
    localparam int TW = 3, RW = 3, NLK = 4;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [NDISP-1:0]           disp_valid = '0;
    logic [NDISP-1:0][PC_W-1:0] disp_pc = '0;
    logic [NDISP-1:0][RW-1:0]   disp_dreg = '0;
    logic                       disp_ready;
    logic [NDISP-1:0][TW-1:0]   disp_tag;
    logic [NLK-1:0][RW-1:0]     lk_reg = '0;
    logic [NLK-1:0]             lk_rdy;
    logic [NLK-1:0][XLEN-1:0]   lk_val;
    logic [NLK-1:0][TW-1:0]     lk_tag;
    logic                       wb_valid = 1'b0;
    logic [TW-1:0]              wb_tag = '0;
    logic [XLEN-1:0]            wb_value = '0;
    logic                       wb_exc = 1'b0;
    logic                       cm_valid;
    logic [RW-1:0]              cm_reg;
    logic [XLEN-1:0]            cm_value;
    logic                       flush;
    logic [PC_W-1:0]            exc_pc;

    rob_top dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pc(disp_pc),
        .disp_dreg(disp_dreg), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .lk_reg(lk_reg), .lk_rdy(lk_rdy), .lk_val(lk_val), .lk_tag(lk_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
        .cm_valid(cm_valid), .cm_reg(cm_reg), .cm_value(cm_value),
        .flush(flush), .exc_pc(exc_pc)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    int ncommit = 0, nflush = 0;
    int mtail = 0;
    int m_reg [DEPTH];
    int m_val [DEPTH];
    int m_pc  [DEPTH];
    bit m_exc [DEPTH];
    bit m_done[DEPTH];
    int pend[$];
    bit prev_flush = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: offers a group, checks acceptance and tags, records expectations
    task automatic dispatch(input logic [1:0] v, input int pc0, input int d0,
                            input int pc1, input int d1, input bit exp_acc);
        int pcs[2];
        int ds[2];
        int t;
        pcs[0] = pc0; pcs[1] = pc1; ds[0] = d0; ds[1] = d1;
        @(negedge clk);
        disp_valid   = v;
        disp_pc[0]   = PC_W'(pc0);
        disp_pc[1]   = PC_W'(pc1);
        disp_dreg[0] = RW'(d0);
        disp_dreg[1] = RW'(d1);
        #1;
        chk(disp_ready == exp_acc, "R3", "group acceptance", disp_ready, exp_acc);
        if (exp_acc) begin
            t = mtail;
            for (int s = 0; s < 2; s++) begin
                if (v[s]) begin
                    chk(disp_tag[s] == TW'(t), "R2", "slot tag", disp_tag[s], t);
                    m_pc[t] = pcs[s]; m_reg[t] = ds[s];
                    m_done[t] = 1'b0; m_exc[t] = 1'b0;
                    pend.push_back(t);
                    t = (t + 1) % DEPTH;
                end
            end
            mtail = t;
        end
        @(posedge clk);
        #1;
        disp_valid = '0;
    endtask

    task automatic writeback(input int t, input int v, input bit e);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = TW'(t); wb_value = XLEN'(v); wb_exc = e;
        @(posedge clk);
        #1;
        wb_valid = 1'b0;
        m_val[t] = v; m_exc[t] = e; m_done[t] = 1'b1;
    endtask

    task automatic look(input int q, input int r, input bit er, input int ev,
                        input int et, input string req);
        @(negedge clk);
        lk_reg[q] = RW'(r);
        #1;
        chk(lk_rdy[q] == er, req, "lookup ready", lk_rdy[q], er);
        if (er) chk(lk_val[q] == XLEN'(ev), req, "lookup value", lk_val[q], ev);
        else    chk(lk_tag[q] == TW'(et), req, "lookup tag", lk_tag[q], et);
    endtask

    // monitor: pops expected retirements in program order
    always @(negedge clk) begin
        int t;
        if (rst_n) begin
            if (cm_valid) begin
                if (pend.size() == 0) begin
                    chk(1'b0, "R5", "retire with nothing pending", 1, 0);
                end else begin
                    t = pend.pop_front();
                    chk(m_done[t] && !m_exc[t], "R5", "retired entry complete and clean", t, t);
                    chk(cm_reg == RW'(m_reg[t]), "R5", "retire register", cm_reg, m_reg[t]);
                    chk(cm_value == XLEN'(m_val[t]), "R5", "retire value", cm_value, m_val[t]);
                    ncommit++;
                end
            end
            if (flush) begin
                chk(!prev_flush, "R6", "flush wider than one cycle", 1, 0);
                chk(disp_ready == 1'b0, "R6", "dispatch open during flush", disp_ready, 0);
                if (!prev_flush) begin
                    if (pend.size() == 0) begin
                        chk(1'b0, "R6", "flush with nothing pending", 1, 0);
                    end else begin
                        t = pend.pop_front();
                        chk(m_done[t] && m_exc[t], "R6", "flush caused by oldest excepting", t, t);
                        chk(exc_pc == PC_W'(m_pc[t]), "R6", "exception address", exc_pc, m_pc[t]);
                    end
                    pend.delete();
                    mtail = 0;
                    nflush++;
                end
            end
            prev_flush = flush;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        #1;
        chk(disp_ready == 1'b1, "R1", "ready after reset", disp_ready, 1);
        chk(cm_valid == 1'b0, "R1", "no retire after reset", cm_valid, 0);
        chk(flush == 1'b0, "R1", "no flush after reset", flush, 0);
        look(0, 3, 1'b1, 0, 0, "R1 R8");

        // R9 same-group dependency, probed without a clock edge
        @(negedge clk);
        disp_valid = 2'b11; disp_dreg[0] = RW'(1); disp_dreg[1] = RW'(2);
        lk_reg[2] = RW'(1); lk_reg[3] = RW'(4);
        #1;
        chk(lk_rdy[2] == 1'b0, "R9", "group source not ready", lk_rdy[2], 0);
        chk(lk_tag[2] == TW'(0), "R9", "group source tag", lk_tag[2], 0);
        chk(lk_rdy[3] == 1'b1, "R9", "unrelated source from registers", lk_rdy[3], 1);
        disp_valid = '0;

        dispatch(2'b11, 'h40, 1, 'h44, 2, 1'b1);   // tags 0,1
        dispatch(2'b11, 'h48, 2, 'h4C, 5, 1'b1);   // tags 2,3
        look(0, 2, 1'b0, 0, 2, "R7");              // youngest r2 writer
        look(1, 1, 1'b0, 0, 0, "R7");

        writeback(1, 22, 1'b0);
        @(negedge clk);
        #1;
        chk(cm_valid == 1'b0, "R5", "oldest incomplete waits", cm_valid, 0);
        writeback(0, 15, 1'b0);
        look(0, 1, 1'b1, 15, 0, "R4 R7");
        repeat (3) @(negedge clk);
        look(0, 1, 1'b1, 15, 0, "R8");
        look(1, 2, 1'b0, 0, 2, "R7");

        dispatch(2'b11, 'h50, 1, 'h54, 6, 1'b1);   // tags 4,5
        dispatch(2'b11, 'h58, 3, 'h5C, 4, 1'b1);   // tags 0,1 after wrap
        dispatch(2'b01, 'h60, 7, 0, 0, 1'b0);      // full buffer

        writeback(5, 99, 1'b0);
        writeback(4, 7, 1'b1);
        writeback(3, 5, 1'b0);
        writeback(2, 38, 1'b0);
        repeat (6) @(negedge clk);
        chk(nflush == 1, "R6", "flush count", nflush, 1);
        look(0, 6, 1'b1, 0, 0, "R6");              // younger result discarded
        look(1, 5, 1'b1, 5, 0, "R6");
        look(0, 1, 1'b1, 15, 0, "R6");             // faulting result not written

        dispatch(2'b11, 'h70, 7, 'h74, 7, 1'b1);   // tags 0,1
        look(0, 7, 1'b0, 0, 1, "R7");
        dispatch(2'b11, 'h78, 0, 'h7C, 1, 1'b1);   // tags 2,3
        dispatch(2'b01, 'h80, 2, 0, 0, 1'b1);      // tag 4
        dispatch(2'b11, 'h84, 3, 'h88, 3, 1'b0);   // one free, two asked
        dispatch(2'b01, 'h84, 3, 0, 0, 1'b1);      // tag 5

        for (int t = 5; t >= 0; t--) writeback(t, 100 + t, 1'b0);
        repeat (10) @(negedge clk);
        look(0, 7, 1'b1, 101, 0, "R5");
        look(1, 1, 1'b1, 103, 0, "R5");
        chk(ncommit == 10, "R5", "retirement count", ncommit, 10);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule